// File: doc/BRIEF.md
# One-Wire Slave Bit-Timing Engine

This block is the slave-side timing engine for a single open-drain, bidirectional serial line. It runs from a fixed system clock and sees the line through an input that is already synchronised. It can only ever pull the line low, through a pull-down enable. All of its timing comes from clock counts, scaled by a clocks-per-microsecond parameter. It watches each low period on the line. From the length of a low it decides one of three things: a write slot is sampled, a read slot is answered, or a bus reset is recognised and answered with a presence pulse.

Two speed profiles are supported, standard and overdrive. A higher layer decodes commands and sets overdrive with a one-cycle strobe. This engine clears overdrive again when it measures a reset-length low. At standard speed the start of a slot is accepted only after the line has stayed low for one microsecond, which removes short noise spikes. At overdrive every falling edge starts a slot at once.

Received bits, read-slot acknowledges and reset detection reach the higher layer as single-cycle strobes. Before each slot begins, the higher layer presents the next transmit bit and a flag that marks the slot as a read slot.

Top module: `onewire_slave_timing`

## Requirements
- R1: While reset is asserted, and right after it, pullDown is 0, overdrive is 0 and rxStb, txAck and resetStb are 0.
- R2: A low of 480 µs or more, at either speed, gives a resetStb pulse shortly after the line returns high. Because the low first starts a slot, it also delivers a received 0 at the sample point.
- R3: After a reset the engine releases the line for about 20 µs at standard speed, then pulls it low up to about 120 µs after the release. At overdrive the release lasts about 2 µs and the pull lasts up to about 12 µs. This puts the line low 60 to 72 µs (standard) or 7 to 10 µs (overdrive) after the master lets go.
- R4: In a write slot the line is sampled 30 µs (standard) or 3 µs (overdrive) after the falling edge. A high level gives rxBit=1 and a low level gives rxBit=0, each with a one-cycle rxStb.
- R5: In a read slot (txEn=1) with txBit=0, the engine holds the line low from slot start until the sample point. With txBit=1 it never pulls. In both cases txAck pulses once at the sample point.
- R6: At standard speed a low shorter than 1 µs produces no event. At overdrive the same short low is a slot and gives a received 1.
- R7: A one-cycle odSet sets overdrive from the next cycle on. overdrive rises in no other way.
- R8: At overdrive, a low of 50 to 80 µs is a reset and overdrive stays 1.
- R9: At overdrive, a low longer than 80 µs but shorter than 480 µs is a reset and clears overdrive.
- R10: A low of 480 µs or more clears overdrive.
- R11: At standard speed, a low shorter than 480 µs (for example 200 µs) is not a reset. It gives only a received 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineIn | input | 1 | Synchronised line level |
| pullDown | output | 1 | Enables the open-drain pull-down |
| txEn | input | 1 | Next slot is a read slot |
| txBit | input | 1 | Bit to return in the next read slot |
| odSet | input | 1 | Strobe from the higher layer that enters overdrive |
| rxStb | output | 1 | Received-bit strobe |
| rxBit | output | 1 | Received bit value, valid with rxStb |
| txAck | output | 1 | Read slot completed |
| resetStb | output | 1 | Reset detected |
| overdrive | output | 1 | Current speed: 1 means overdrive |

## Verification
Each strobe is registered once, so it appears one cycle after the decision that causes it:
- rxStb and txAck come one cycle after the count since the falling edge reaches the sample point. That is about 121 clocks at standard speed and 13 clocks at overdrive, with four clocks per microsecond.
- resetStb comes two cycles after the master releases the line.

The bench does not pin these strobes to exact cycles. A scoreboard queues the events each stimulus must produce, and a monitor on the falling clock edge compares them in order of arrival. Any event with nothing queued is a failure.

Line levels cannot be queued, so the bench checks them at fixed offsets well inside each window:
- presence is probed at 62 µs and 70 µs after release at standard speed, and at 7.5 µs and 9.5 µs at overdrive;
- a read-0 hold is probed at 15 µs or 2 µs after the fall.

These offsets are clear of the few register delays between a line change and the pull-down.

// File: rtl/owslv_pkg.sv
package owslv_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SLOT,
    S_WAITRISE,
    S_PGAP,
    S_PDRV
  } owState_t;

  typedef struct packed {
    logic tmrSync;
    logic tmrZero;
    logic drive;
    logic rx;
    logic tx;
    logic rst;
    logic clrOd;
    logic setOd;
  } owCtl_t;

endpackage

// File: rtl/owslv_dp.sv
module owslv_dp
  import owslv_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  owCtl_t           ctl,
  output logic [CNT_W-1:0] lowCnt,
  output logic [CNT_W-1:0] tmr,
  output logic             od,
  output logic             pullDown,
  output logic             rxStb,
  output logic             rxBit,
  output logic             txAck,
  output logic             resetStb
);

  // Length of the current low period, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lowCnt <= '0;
    else if (lineIn)         lowCnt <= '0;
    else if (lowCnt != '1)   lowCnt <= lowCnt + 1'b1;
  end

  // Phase timer: aligned to the low counter at slot start, zeroed for presence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tmr <= '0;
    else if (ctl.tmrSync) tmr <= lowCnt + 1'b1;
    else if (ctl.tmrZero) tmr <= '0;
    else if (tmr != '1)   tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          od <= 1'b0;
    else if (ctl.clrOd) od <= 1'b0;
    else if (ctl.setOd) od <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pullDown <= 1'b0;
      rxStb    <= 1'b0;
      rxBit    <= 1'b0;
      txAck    <= 1'b0;
      resetStb <= 1'b0;
    end else begin
      pullDown <= ctl.drive;
      rxStb    <= ctl.rx;
      txAck    <= ctl.tx;
      resetStb <= ctl.rst;
      if (ctl.rx) rxBit <= lineIn;
    end
  end

endmodule

// File: rtl/owslv_ctrl.sv
module owslv_ctrl
  import owslv_pkg::*;
#(
  parameter int CYC_PER_US = 50,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic             od,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic [CNT_W-1:0] tmr,
  input  logic             txEn,
  input  logic             txBit,
  input  logic             odSet,
  output owCtl_t           ctl
);

  localparam logic [CNT_W-1:0] K_FILT     = CNT_W'(CYC_PER_US);
  localparam logic [CNT_W-1:0] K_ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] K_SAMP_STD = CNT_W'(30 * CYC_PER_US);
  localparam logic [CNT_W-1:0] K_SAMP_OD  = CNT_W'(3 * CYC_PER_US);
  localparam logic [CNT_W-1:0] K_GAP_STD  = CNT_W'(20 * CYC_PER_US);
  localparam logic [CNT_W-1:0] K_GAP_OD   = CNT_W'(2 * CYC_PER_US);
  localparam logic [CNT_W-1:0] K_PRS_STD  = CNT_W'(100 * CYC_PER_US);
  localparam logic [CNT_W-1:0] K_PRS_OD   = CNT_W'(10 * CYC_PER_US);
  localparam logic [CNT_W-1:0] K_RST_STD  = CNT_W'(480 * CYC_PER_US);
  localparam logic [CNT_W-1:0] K_RST_OD   = CNT_W'(50 * CYC_PER_US);
  localparam logic [CNT_W-1:0] K_OD_MAX   = CNT_W'(80 * CYC_PER_US);

  owState_t state, nxt;
  logic driveBit, isRead;

  logic [CNT_W-1:0] acceptLvl, sampT, gapT, prsT;
  logic isRst, dropOd;

  assign acceptLvl = od ? K_ONE     : K_FILT;
  assign sampT     = od ? K_SAMP_OD : K_SAMP_STD;
  assign gapT      = od ? K_GAP_OD  : K_GAP_STD;
  assign prsT      = od ? K_PRS_OD  : K_PRS_STD;
  assign isRst     = (lowCnt >= K_RST_STD) || (od && lowCnt >= K_RST_OD);
  assign dropOd    = (lowCnt >= K_RST_STD) || (lowCnt > K_OD_MAX);

  always_comb begin
    ctl       = '0;
    ctl.setOd = odSet;
    nxt       = state;
    unique case (state)
      S_IDLE: begin
        if (!lineIn && lowCnt >= acceptLvl) begin
          ctl.tmrSync = 1'b1;
          nxt         = S_SLOT;
        end
      end
      S_SLOT: begin
        ctl.drive = driveBit;
        if (tmr == sampT) begin
          ctl.rx = !isRead;
          ctl.tx = isRead;
          nxt    = S_WAITRISE;
        end
      end
      S_WAITRISE: begin
        if (lineIn) begin
          if (isRst) begin
            ctl.rst     = 1'b1;
            ctl.clrOd   = dropOd;
            ctl.tmrZero = 1'b1;
            nxt         = S_PGAP;
          end else begin
            nxt = S_IDLE;
          end
        end
      end
      S_PGAP: begin
        if (tmr == gapT) begin
          ctl.tmrZero = 1'b1;
          nxt         = S_PDRV;
        end
      end
      S_PDRV: begin
        ctl.drive = 1'b1;
        if (tmr == prsT) nxt = S_WAITRISE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      driveBit <= 1'b0;
      isRead   <= 1'b0;
    end else begin
      state <= nxt;
      if (ctl.tmrSync) begin
        driveBit <= txEn && !txBit;
        isRead   <= txEn;
      end
    end
  end

endmodule

// File: rtl/onewire_slave_timing.sv
module onewire_slave_timing
  import owslv_pkg::*;
#(
  parameter int CYC_PER_US = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic pullDown,
  input  logic txEn,
  input  logic txBit,
  input  logic odSet,
  output logic rxStb,
  output logic rxBit,
  output logic txAck,
  output logic resetStb,
  output logic overdrive
);

  localparam int CNT_W = $clog2(700 * CYC_PER_US + 1);

  owCtl_t           ctl;
  logic [CNT_W-1:0] lowCnt;
  logic [CNT_W-1:0] tmr;

  owslv_ctrl #(.CYC_PER_US(CYC_PER_US), .CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .od     (overdrive),
    .lowCnt (lowCnt),
    .tmr    (tmr),
    .txEn   (txEn),
    .txBit  (txBit),
    .odSet  (odSet),
    .ctl    (ctl)
  );

  owslv_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .ctl      (ctl),
    .lowCnt   (lowCnt),
    .tmr      (tmr),
    .od       (overdrive),
    .pullDown (pullDown),
    .rxStb    (rxStb),
    .rxBit    (rxBit),
    .txAck    (txAck),
    .resetStb (resetStb)
  );

endmodule

// File: rtl/owslv_chk.sv
module owslv_chk (
  input logic clk,
  input logic rstN,
  input logic lineIn,
  input logic pullDown,
  input logic odSet,
  input logic rxStb,
  input logic txAck,
  input logic resetStb,
  input logic overdrive
);

  assert_rst_on_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    resetStb |-> lineIn);

  assert_rx_no_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxStb |-> !pullDown);

  assert_rx_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxStb |=> !rxStb);

  assert_tx_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    txAck |=> !txAck);

  assert_od_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overdrive) |-> $past(odSet));

  assert_od_exit_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overdrive) |-> resetStb);

endmodule

bind onewire_slave_timing owslv_chk i_owslv_chk (
  .clk       (clk),
  .rstN      (rstN),
  .lineIn    (lineIn),
  .pullDown  (pullDown),
  .odSet     (odSet),
  .rxStb     (rxStb),
  .txAck     (txAck),
  .resetStb  (resetStb),
  .overdrive (overdrive)
);

// File: tb/test_onewire_slave_timing.sv
`timescale 1ns/1ps
module test_onewire_slave_timing;

  localparam int CPU = 4;  // clocks per microsecond in this bench

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mLow = 1'b0;
  logic txEn = 1'b0;
  logic txBit = 1'b0;
  logic odSet = 1'b0;
  logic lineIn, pullDown, rxStb, rxBit, txAck, resetStb, overdrive;
  logic done = 1'b0;

  assign lineIn = !(mLow || pullDown);

  always #2.5 clk = ~clk;

  onewire_slave_timing #(.CYC_PER_US(CPU)) i_onewire_slave_timing (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .pullDown(pullDown),
    .txEn(txEn), .txBit(txBit), .odSet(odSet), .rxStb(rxStb), .rxBit(rxBit),
    .txAck(txAck), .resetStb(resetStb), .overdrive(overdrive)
  );

  int errs = 0;
  int checks = 0;
  int qKind[$];
  bit qBit[$];
  string qTag[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // kind: 0 received bit, 1 read ack, 2 reset
  task automatic expectEv(int k, bit b, string tag);
    qKind.push_back(k);
    qBit.push_back(b);
    qTag.push_back(tag);
  endtask

  task automatic popCmp(int k, bit b);
    if (qKind.size() == 0) begin
      chk(1'b0, "R6 R11 unexpected event kind", k, -1);
    end else begin
      int ek = qKind.pop_front();
      bit eb = qBit.pop_front();
      string et = qTag.pop_front();
      chk(k == ek && b == eb, et, k * 2 + b, ek * 2 + eb);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rxStb)    popCmp(0, rxBit);
      if (txAck)    popCmp(1, 1'b0);
      if (resetStb) popCmp(2, 1'b0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic slot(int lowC, int totC);
    mLow = 1'b1;
    cyc(lowC);
    mLow = 1'b0;
    cyc(totC - lowC);
  endtask

  task automatic readSlot(int lowC, int chkC, int totC, bit expLow, string tag);
    mLow = 1'b1;
    cyc(lowC);
    mLow = 1'b0;
    cyc(chkC - lowC);
    #1 chk(lineIn == !expLow, tag, lineIn, !expLow);
    cyc(totC - chkC);
  endtask

  task automatic rstLow(int lowC, int hiC, int c1, int c2, int tail);
    mLow = 1'b1;
    cyc(lowC);
    mLow = 1'b0;
    cyc(hiC);
    #1 chk(lineIn == 1'b1, "R3 line free before presence", lineIn, 1);
    cyc(c1 - hiC);
    #1 chk(lineIn == 1'b0, "R3 presence early probe", lineIn, 0);
    cyc(c2 - c1);
    #1 chk(lineIn == 1'b0, "R3 presence late probe", lineIn, 0);
    cyc(tail - c2);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog R1 run did not finish actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(10);
    chk(pullDown == 0, "R1 pullDown in reset", pullDown, 0);
    chk(overdrive == 0, "R1 overdrive in reset", overdrive, 0);
    chk({rxStb, txAck, resetStb} == 3'b000, "R1 strobes in reset",
        {rxStb, txAck, resetStb}, 0);
    rstN = 1'b1;
    cyc(20);
    chk(pullDown == 0 && overdrive == 0, "R1 idle after reset",
        {pullDown, overdrive}, 0);

    // standard reset with presence
    expectEv(0, 1'b0, "R2 reset low gives bit 0");
    expectEv(2, 1'b0, "R2 reset strobe");
    rstLow(2000, 40, 248, 280, 1200);
    chk(overdrive == 0, "R10 standard after long low", overdrive, 0);

    // standard write slots
    expectEv(0, 1'b0, "R4 std write 0");
    slot(280, 360);
    expectEv(0, 1'b1, "R4 std write 1");
    slot(20, 360);

    // standard read slots
    txEn = 1'b1; txBit = 1'b0;
    expectEv(1, 1'b0, "R5 std read ack bit0");
    readSlot(8, 60, 360, 1'b1, "R5 std read 0 holds low");
    txBit = 1'b1;
    expectEv(1, 1'b0, "R5 std read ack bit1");
    readSlot(8, 60, 360, 1'b0, "R5 std read 1 no pull");
    txEn = 1'b0; txBit = 1'b0;

    // standard glitch is filtered
    slot(2, 360);
    chk(qKind.size() == 0, "R6 std glitch ignored", qKind.size(), 0);

    // enter overdrive
    odSet = 1'b1;
    cyc(1);
    odSet = 1'b0;
    chk(overdrive == 1, "R7 odSet enters overdrive", overdrive, 1);

    expectEv(0, 1'b1, "R6 od short low is slot");
    slot(2, 120);
    expectEv(0, 1'b0, "R4 od write 0");
    slot(40, 120);
    txEn = 1'b1; txBit = 1'b0;
    expectEv(1, 1'b0, "R5 od read ack");
    readSlot(4, 8, 120, 1'b1, "R5 od read 0 holds low");
    txEn = 1'b0;

    // overdrive reset keeps overdrive
    expectEv(0, 1'b0, "R8 od reset low bit 0");
    expectEv(2, 1'b0, "R8 od reset strobe");
    rstLow(240, 4, 30, 38, 200);
    chk(overdrive == 1, "R8 overdrive kept", overdrive, 1);

    // mid-length low at overdrive drops speed
    expectEv(0, 1'b0, "R9 mid low bit 0");
    expectEv(2, 1'b0, "R9 mid low reset");
    rstLow(800, 40, 248, 280, 1200);
    chk(overdrive == 0, "R9 overdrive cleared", overdrive, 0);

    // long low at overdrive drops speed
    odSet = 1'b1;
    cyc(1);
    odSet = 1'b0;
    expectEv(0, 1'b0, "R10 long low bit 0");
    expectEv(2, 1'b0, "R10 long low reset");
    rstLow(2000, 40, 248, 280, 1200);
    chk(overdrive == 0, "R10 overdrive cleared", overdrive, 0);

    // standard 200 us low is not a reset
    expectEv(0, 1'b0, "R11 std mid low bit 0");
    slot(800, 1200);
    chk(overdrive == 0, "R11 speed unchanged", overdrive, 0);

    chk(qKind.size() == 0, "R2 all expected events seen", qKind.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule